// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 36-bit words in one direction between two clock domains. A producer on the write clock pushes words in and a consumer on the read clock takes them out in the same order. The two clocks run freely and may be unrelated, or they may be one and the same clock. Write and read pointers cross between the domains as Gray code through two-stage synchronizers. The storage depth is a parameter, and the default build holds 256 words.

At master reset the block samples two settings. The first is the read timing. In standard timing a read request fetches the next word onto the output one read-clock edge later. In first-word-fall-through timing the oldest word is placed on the output without being asked for. The second setting is the almost-empty and almost-full offset source: a preset value, or a programmable register loaded serially or in parallel. A partial reset empties the buffer but keeps both settings.

Both stream edges use valid/ready rules. On the write side `wr_req` is valid and the not-full condition is ready. A word is taken on a write-clock edge only while the block is not full, and a request made while full is dropped. In first-word-fall-through timing the read side turns around: `rd_stat` is valid, `rd_req` is ready, and the word on `rd_data` is held until it is consumed.

Top module: `xclk_fifo`

## Requirements
- R1: After master or partial reset, with no writes since: in standard timing `wr_stat`=0 (not full) and `rd_stat`=1 (empty); in fall-through timing `wr_stat`=1 (input ready) and `rd_stat`=0 (no output). In both timings `aempty`=1 and `afull`=0.
- R2: Every accepted word is delivered on `rd_data` exactly once, in write order, across both clock domains.
- R3: Once 256 words are held in storage, the full condition is asserted (`wr_stat`=1 in standard timing). A write requested while full is dropped and changes no stored word.
- R4: In standard timing, `rd_req` while not empty places the next word on `rd_data` after the next `rclk` rising edge. While empty, `rd_req` is ignored and `rd_data` holds its last value.
- R5: In fall-through timing, the first word written into an empty FIFO appears on `rd_data` with `rd_stat`=1 and no request made. `rd_req` while `rd_stat`=1 consumes that word.
- R6: `aempty`=1 exactly when the count of undelivered words is at or below the almost-empty offset. In fall-through timing that count includes the word waiting on `rd_data`.
- R7: `afull`=1 exactly when the free space in storage (256 minus words written and not yet taken out of storage) is at or below the almost-full offset.
- R8: While `mrst_n`=0, `fwft_sel` picks the timing (1 = fall-through) and `off_sel` picks the offset source: 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 64 for both offsets, and 2'b00 selects programming.
- R9: With `off_sel`=2'b00 the offsets form a 16-bit register {almost-empty[15:8], almost-full[7:0]}. Each `wclk` edge with `ser_en`=1 shifts it left by one and enters `ser_din` at bit 0. Each `wclk` edge with `par_ld`=1 loads it from `wr_data[15:0]`, and `par_ld` wins over `ser_en`. With a preset selected, both `ser_en` and `par_ld` are ignored.
- R10: `prst_n`=0 discards all stored words but keeps the timing mode and the offsets, including programmed ones.
- R11: When one clock drives both sides, a write and a read on the same edge are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; clears data and samples configuration |
| prst_n | input | 1 | Partial reset, active low; clears data only |
| fwft_sel | input | 1 | Timing select sampled at master reset (1 = fall-through) |
| off_sel | input | 2 | Offset source sampled at master reset |
| ser_din | input | 1 | Serial offset data bit |
| ser_en | input | 1 | Serial offset shift enable |
| par_ld | input | 1 | Parallel offset load from wr_data[15:0] |
| wr_req | input | 1 | Write valid |
| wr_data | input | 36 | Write word |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| afull | output | 1 | Almost-full flag |
| rd_req | input | 1 | Read request (standard) or consume (fall-through) |
| rd_data | output | 36 | Read word |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| aempty | output | 1 | Almost-empty flag |

## Verification
With a single clock on both sides, an accepted write and a read of a waiting word can land on the same edge. This happens in fall-through timing, and the bench provokes it by asserting both requests every cycle for 40 cycles with about twenty words in flight. It judges the result by counting acceptances on each side, which must both equal 40, by matching every consumed word against its own ordered queue, and by checking that the almost-empty flag agrees with the unchanged word count after the clocks have settled.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;
  typedef enum logic [1:0] {
    OFS_PROG = 2'b00,
    OFS_P8   = 2'b01,
    OFS_P16  = 2'b10,
    OFS_P64  = 2'b11
  } ofs_src_e;
endpackage

// File: rtl/xcf_sync.sv
`timescale 1ns/1ps
module xcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/xcf_cfg.sv
`timescale 1ns/1ps
module xcf_cfg
  import xcf_pkg::*;
#(
  parameter int OFFW = 8
) (
  input  logic            wclk,
  input  logic            mrst_n,
  input  logic            run_n,
  input  logic            fwft_sel,
  input  logic [1:0]      off_sel,
  input  logic            ser_din,
  input  logic            ser_en,
  input  logic            par_ld,
  input  logic [2*OFFW-1:0] par_word,
  output logic            fwft,
  output logic [OFFW-1:0] ae_off,
  output logic [OFFW-1:0] af_off
);
  ofs_src_e src;
  logic [OFFW-1:0] preset;

  always_comb begin
    unique case (ofs_src_e'(off_sel))
      OFS_P8:  preset = OFFW'(8);
      OFS_P16: preset = OFFW'(16);
      OFS_P64: preset = OFFW'(64);
      default: preset = '0;
    endcase
  end

  // configuration is loaded while master reset is held, then frozen
  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft   <= fwft_sel;
      src    <= ofs_src_e'(off_sel);
      ae_off <= preset;
      af_off <= preset;
    end else if (run_n && src == OFS_PROG) begin
      if (par_ld) begin
        {ae_off, af_off} <= par_word;
      end else if (ser_en) begin
        {ae_off, af_off} <= {ae_off[OFFW-2:0], af_off, ser_din};
      end
    end
  end
endmodule

// File: rtl/xcf_wside.sv
`timescale 1ns/1ps
module xcf_wside #(
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_off,
  output logic          wen,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wcnt,
  output logic          full,
  output logic          afull,
  output logic          wr_stat
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin_s, wbin_nx, free;

  assign rbin_s  = g2b(rgray_s);
  assign wcnt    = wbin - rbin_s;
  assign full    = (wcnt == CAP);
  assign wen     = wr_req & ~full;
  assign wbin_nx = wbin + (AW+1)'(wen);
  assign free    = CAP - wcnt;
  assign afull   = (free <= {1'b0, af_off});
  assign wr_stat = fwft ? ~full : full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end
endmodule

// File: rtl/xcf_rside.sv
`timescale 1ns/1ps
module xcf_rside #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          mempty,
  output logic          ordy,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          aempty
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] mcnt, rbin_nx;
  logic [AW+1:0] pend;
  logic ld;

  assign mcnt    = g2b(wgray_s) - rbin;
  assign mempty  = (mcnt == '0);
  // standard: fetch on request; fall-through: refill the output stage
  assign ld      = fwft ? (~mempty & (~ordy | rd_req)) : (rd_req & ~mempty);
  assign rbin_nx = rbin + (AW+1)'(ld);
  assign pend    = {1'b0, mcnt} + (AW+2)'(fwft & ordy);
  assign aempty  = (pend <= (AW+2)'(ae_off));
  assign rd_stat = fwft ? ordy : mempty;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      ordy    <= 1'b0;
      rd_data <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      if (ld) rd_data <= mem_q;
      if (fwft) begin
        if (ld) ordy <= 1'b1;
        else if (rd_req) ordy <= 1'b0;
      end else begin
        ordy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DW    = 36,
  parameter int DEPTH = 256
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    off_sel,
  input  logic          ser_din,
  input  logic          ser_en,
  input  logic          par_ld,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stat,
  output logic          afull,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          aempty
);
  localparam int AW = $clog2(DEPTH);

  logic clr_n, wrst_n, rrst_n, fwft, wen, full, mempty, ordy;
  logic [AW-1:0] ae_off, af_off;
  logic [AW:0] wbin, wgray, wcnt, rbin, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem [DEPTH];

  assign clr_n = mrst_n & prst_n;

  // reset asserts at once, releases in step with each clock
  xcf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(clr_n), .d(1'b1), .q(wrst_n));
  xcf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(clr_n), .d(1'b1), .q(rrst_n));

  xcf_cfg #(.OFFW(AW)) u_cfg (
    .wclk(wclk), .mrst_n(mrst_n), .run_n(wrst_n), .fwft_sel(fwft_sel),
    .off_sel(off_sel), .ser_din(ser_din), .ser_en(ser_en), .par_ld(par_ld),
    .par_word(wr_data[2*AW-1:0]), .fwft(fwft), .ae_off(ae_off), .af_off(af_off)
  );

  xcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  xcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  xcf_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .rst_n(wrst_n), .fwft(fwft), .wr_req(wr_req),
    .rgray_s(rgray_s), .af_off(af_off), .wen(wen), .wbin(wbin),
    .wgray(wgray), .wcnt(wcnt), .full(full), .afull(afull), .wr_stat(wr_stat)
  );

  always_ff @(posedge wclk) begin
    if (wen) mem[wbin[AW-1:0]] <= wr_data;
  end

  xcf_rside #(.AW(AW), .DW(DW)) u_rside (
    .rclk(rclk), .rst_n(rrst_n), .fwft(fwft), .rd_req(rd_req),
    .wgray_s(wgray_s), .ae_off(ae_off), .mem_q(mem[rbin[AW-1:0]]),
    .rbin(rbin), .rgray(rgray), .mempty(mempty), .ordy(ordy),
    .rd_data(rd_data), .rd_stat(rd_stat), .aempty(aempty)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int AW = 8
) (
  input logic        wclk,
  input logic        rclk,
  input logic        wrst_n,
  input logic        rrst_n,
  input logic        wr_req,
  input logic        full,
  input logic        afull,
  input logic        mempty,
  input logic        ordy,
  input logic        aempty,
  input logic [AW:0] wbin,
  input logic [AW:0] wgray,
  input logic [AW:0] wcnt,
  input logic [AW:0] rbin,
  input logic [AW:0] rgray
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcnt <= CAP); // R3
  AST_FULL_DROPS_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wr_req) |=> $stable(wbin)); // R3
  AST_EMPTY_NO_FETCH: assert property (@(posedge rclk) disable iff (!rrst_n)
    mempty |=> $stable(rbin)); // R4
  AST_FULL_HAS_AF: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> afull); // R7
  AST_DRAINED_HAS_AE: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mempty && !ordy) |-> aempty); // R6
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_req(wr_req), .full(full), .afull(afull), .mempty(mempty),
  .ordy(ordy), .aempty(aempty), .wbin(wbin), .wgray(wgray),
  .wcnt(wcnt), .rbin(rbin), .rgray(rgray)
);

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb;
  logic wclk = 1'b0, aclk = 1'b0, same_clk = 1'b0, rclk;
  logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic [1:0] off_sel = 2'b01;
  logic ser_din = 1'b0, ser_en = 1'b0, par_ld = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [35:0] wr_data = '0;
  logic wr_stat, afull, rd_stat, aempty;
  logic [35:0] rd_data;
  int vecs = 0, miss = 0;
  logic [35:0] q [$];

  always #5 wclk = ~wclk;
  always #7 aclk = ~aclk;
  assign rclk = same_clk ? wclk : aclk;

  xclk_fifo u_dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .off_sel(off_sel), .ser_din(ser_din),
    .ser_en(ser_en), .par_ld(par_ld), .wr_req(wr_req), .wr_data(wr_data),
    .wr_stat(wr_stat), .afull(afull), .rd_req(rd_req), .rd_data(rd_data),
    .rd_stat(rd_stat), .aempty(aempty)
  );

  function automatic logic [35:0] pat(input int k);
    return {4'hA, k[15:0], ~k[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (16) @(negedge wclk);
  endtask

  task automatic mreset(input logic fw, input logic [1:0] sel, input logic same);
    @(negedge wclk);
    mrst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; ser_en = 1'b0; par_ld = 1'b0;
    fwft_sel = fw; off_sel = sel; same_clk = same;
    repeat (6) @(negedge wclk);
    mrst_n = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic preset_pulse();
    @(negedge wclk) prst_n = 1'b0;
    repeat (4) @(negedge wclk);
    prst_n = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic wr1(input logic [35:0] d);
    @(negedge wclk); wr_req = 1'b1; wr_data = d;
    @(negedge wclk); wr_req = 1'b0;
  endtask

  task automatic rd_std(output logic [35:0] d);
    @(negedge rclk) rd_req = 1'b1;
    @(negedge rclk) rd_req = 1'b0;
    d = rd_data;
  endtask

  task automatic ser_load(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      @(negedge wclk); ser_en = 1'b1; ser_din = v[i];
    end
    @(negedge wclk) ser_en = 1'b0;
  endtask

  task automatic par_load(input logic [15:0] v);
    @(negedge wclk); par_ld = 1'b1; wr_data = {20'h0, v};
    @(negedge wclk) par_ld = 1'b0;
  endtask

  // write words from..to; k is the running total of undelivered words
  task automatic sweep(input int from, input int to, input int ae, input int af,
                       input logic do_af, input logic std);
    for (int k = from; k <= to; k++) begin
      wr1(pat(k));
      q.push_back(pat(k));
      settle();
      chk("R6 aempty", {35'h0, aempty}, {35'h0, (k <= ae)});
      if (do_af) chk("R7 afull", {35'h0, afull}, {35'h0, ((256 - k) <= af)});
      if (std) chk("R3 full", {35'h0, wr_stat}, {35'h0, (k == 256)});
    end
  endtask

  initial begin
    #1_500_000;
    miss++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [35:0] d;
    int pushes, pops, nxt;

    // standard timing, preset 8
    mreset(1'b0, 2'b01, 1'b0);
    chk("R1 full after reset", {35'h0, wr_stat}, 36'h0);
    chk("R1 empty after reset", {35'h0, rd_stat}, 36'h1);
    chk("R1 aempty after reset", {35'h0, aempty}, 36'h1);
    chk("R1 afull after reset", {35'h0, afull}, 36'h0);
    sweep(1, 256, 8, 8, 1'b1, 1'b1);                      // R8 preset 8
    wr1(36'hBAD00BAD0);                                   // R3 dropped
    settle();
    chk("R3 still full", {35'h0, wr_stat}, 36'h1);
    for (int i = 1; i <= 256; i++) begin
      rd_std(d);
      chk("R2 order std", d, q.pop_front());
      settle();
      chk("R6 aempty drain", {35'h0, aempty}, {35'h0, ((256 - i) <= 8)});
    end
    chk("R4 empty after drain", {35'h0, rd_stat}, 36'h1);
    rd_std(d);
    chk("R4 read on empty ignored", d, pat(256));
    wr1(pat(300));
    settle();
    rd_std(d);
    chk("R4 pointer intact", d, pat(300));

    // fall-through, preset 16, one shared clock
    mreset(1'b1, 2'b10, 1'b1);
    chk("R1 irdy after reset", {35'h0, wr_stat}, 36'h1);
    chk("R1 ordy after reset", {35'h0, rd_stat}, 36'h0);
    sweep(1, 1, 16, 0, 1'b0, 1'b0);
    chk("R5 ordy without request", {35'h0, rd_stat}, 36'h1);
    chk("R5 first word shown", rd_data, pat(1));
    sweep(2, 20, 16, 0, 1'b0, 1'b0);                      // R8 preset 16
    pushes = 0; pops = 0; nxt = 1000;
    for (int i = 0; i < 40; i++) begin
      @(negedge wclk);
      if (rd_stat) begin
        chk("R11 same-edge order", rd_data, q.pop_front());
        pops++;
      end
      rd_req = rd_stat;
      wr_req = 1'b1; wr_data = pat(nxt);
      if (wr_stat) begin
        q.push_back(pat(nxt));
        pushes++;
        nxt++;
      end
    end
    @(negedge wclk); wr_req = 1'b0; rd_req = 1'b0;
    chk("R11 reads accepted", 36'(pops), 36'd40);
    chk("R11 writes accepted", 36'(pushes), 36'd40);
    settle();
    chk("R11 level kept", {35'h0, aempty}, 36'h0);

    // partial reset keeps fall-through and offset 16
    preset_pulse();
    chk("R10 ordy cleared", {35'h0, rd_stat}, 36'h0);
    chk("R10 mode kept", {35'h0, wr_stat}, 36'h1);
    chk("R10 aempty cleared", {35'h0, aempty}, 36'h1);
    sweep(1, 17, 16, 0, 1'b0, 1'b0);
    chk("R10 old data gone", rd_data, pat(1));

    // programmed offsets: serial ae=5 af=3
    mreset(1'b0, 2'b00, 1'b0);
    ser_load({8'd5, 8'd3});
    sweep(1, 256, 5, 3, 1'b1, 1'b1);                      // R9 serial
    preset_pulse();
    par_load({8'd2, 8'd250});
    sweep(1, 8, 2, 250, 1'b1, 1'b1);                      // R9 parallel

    // preset 64 ignores both loading paths
    mreset(1'b0, 2'b11, 1'b0);
    ser_load(16'h0000);
    par_load(16'h0101);
    sweep(1, 70, 64, 64, 1'b1, 1'b1);                     // R9 ignored, R8 preset 64

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule